// File: doc/BRIEF.md
# Wavefront Issue Scheduler with Read-Port Arbitration

This block is the issue stage of a GPU-style compute unit. The unit has a number of vector SIMD units and a number of memory pipes. The memory pipes are the global-memory pipes plus the shared-memory pipes. Every execution resource owns one dispatch slot. The slots for SIMD units come first, and the memory-pipe slots follow them. The surrounding logic gives each resource a bitmask of the wave slots that are ready for it. For every wave it also gives the SIMD unit the wave is bound to, and the register-file read banks that wave's next instruction will read this cycle.

In every cycle the scheduler works in two passes. In the first pass, each resource picks one ready wave on its own, using a round-robin pointer. In the second pass, the memory-pipe slots are visited in ascending order. A memory-pipe issue that shares a SIMD unit, and so a vector register file, with another issue is compared with it. If their read-bank masks overlap, the memory issue keeps its slot. The competing issue is dropped and its wave is flagged to return to the ready state.

The results are registered. The slots, the block strobes for the waves that were kept and the requeue strobes for the waves that were dropped all appear one clock after the inputs. The owner of the ready lists uses the block strobes to remove issued waves and the requeue strobes to restore dropped ones.

Top module: `wave_issue_sched`

## Requirements
- R1: Resource r with an all-zero ready mask leaves slot r empty in the next cycle: `slotValid[r]=0` and slot wave 0. Slot indices below NUM_SIMD are SIMD units. The indices from NUM_SIMD up to NUM_SIMD+NUM_GMEM_PIPES+NUM_SMEM_PIPES-1 are memory pipes.
- R2: A resource with a non-empty ready mask chooses the first ready wave index at or after its round-robin pointer, wrapping from NUM_WAVES-1 to 0. All pointers are 0 after reset. A pointer moves to the chosen index plus one, modulo NUM_WAVES, only when that issue survives arbitration.
- R3: A surviving issue shows up one cycle later as `slotValid[r]=1`, with the wave index in field r of `slotWave` (bits r*WAVE_W upward). The same cycle also sets bit w of `waveBlock` for that wave w.
- R4: Two issues conflict only when both of these hold: their waves have equal SIMD ids (field w of `waveSimd`), and their read-bank masks (field w of `waveBanks`) have a non-zero AND. Any other pair never causes an eviction.
- R5: When a memory-pipe slot conflicts with another slot, the memory-pipe issue is kept. The other slot reads empty (valid 0, wave 0), and the bit of its wave is set in `waveRequeue`.
- R6: Each memory-pipe slot evicts at most one other slot per cycle. The one it evicts is the lowest-indexed filled slot that conflicts with it.
- R7: Memory-pipe slots are arbitrated in ascending index order. A memory slot already evicted by an earlier memory slot takes no part as an aggressor, and later memory slots no longer see it as a candidate.
- R8: Two SIMD-slot issues never evict each other. When no memory pipe issues, `waveRequeue` stays zero.
- R9: While reset is held, and in the first cycle after it, all slots are empty and `waveBlock` and `waveRequeue` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| readyMask | input | NUM_RES*NUM_WAVES | Ready waves, one NUM_WAVES field per resource |
| waveSimd | input | NUM_WAVES*SIMD_W | SIMD id of each wave |
| waveBanks | input | NUM_WAVES*NUM_BANKS | Read-bank mask of each wave for this cycle |
| slotValid | output | NUM_RES | Dispatch slot filled |
| slotWave | output | NUM_RES*WAVE_W | Wave index held in each slot |
| waveBlock | output | NUM_WAVES | Wave issued and now blocked |
| waveRequeue | output | NUM_WAVES | Wave evicted by arbitration and ready again |

## Verification
The hardest case to reach is a chain. One memory pipe evicts a second memory pipe, and that second memory pipe would itself have evicted a SIMD slot. Getting there needs three resources to pick waves on the same SIMD with overlapping banks, all in one cycle, while the round-robin pointers sit where the bench expects. The bench programs the wave table and ready masks directly for this chain. It does the same for the two-victim and the SIMD-against-SIMD cases. It then runs a long pseudo-random sweep with narrow bank masks and a one-bit SIMD id, so that conflicts are frequent. Throughout the sweep, a bench model of the pointers predicts every slot and strobe.

// File: rtl/wave_issue_pkg.sv
package wave_issue_pkg;
  // per-slot outcome of the arbitration pass, sent from control to datapath
  typedef struct packed {
    logic keep;   // slot issues this cycle
    logic evict;  // slot was filled but lost a read-port conflict
  } slotVerdict_t;
endpackage

// File: rtl/wave_issue_pick.sv
module wave_issue_pick
  import wave_issue_pkg::*;
#(
  parameter int NUM_RES   = 4,
  parameter int NUM_WAVES = 4,
  parameter int NUM_BANKS = 4,
  parameter int SIMD_W    = 1,
  parameter int WAVE_W    = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_RES*NUM_WAVES-1:0]  readyMask,
  input  logic [NUM_WAVES*SIMD_W-1:0]   waveSimd,
  input  logic [NUM_WAVES*NUM_BANKS-1:0] waveBanks,
  input  slotVerdict_t                  verdict [NUM_RES],
  output logic [NUM_RES-1:0]            candFill,
  output logic [NUM_RES*SIMD_W-1:0]     candSimd,
  output logic [NUM_RES*NUM_BANKS-1:0]  candBanks,
  output logic [NUM_RES-1:0]            slotValid,
  output logic [NUM_RES*WAVE_W-1:0]     slotWave,
  output logic [NUM_WAVES-1:0]          waveBlock,
  output logic [NUM_WAVES-1:0]          waveRequeue
);
  logic [WAVE_W-1:0] rrPtr    [NUM_RES];
  logic [WAVE_W-1:0] candWave [NUM_RES];

  // first pass: each resource picks independently, round robin from its pointer
  always_comb begin
    for (int r = 0; r < NUM_RES; r++) begin
      candFill[r] = 1'b0;
      candWave[r] = '0;
      for (int k = 0; k < NUM_WAVES; k++) begin
        int idx;
        idx = (int'(rrPtr[r]) + k) % NUM_WAVES;
        if (!candFill[r] && readyMask[r*NUM_WAVES + idx]) begin
          candFill[r] = 1'b1;
          candWave[r] = WAVE_W'(idx);
        end
      end
      candSimd[r*SIMD_W +: SIMD_W]      = waveSimd[int'(candWave[r])*SIMD_W +: SIMD_W];
      candBanks[r*NUM_BANKS +: NUM_BANKS] = waveBanks[int'(candWave[r])*NUM_BANKS +: NUM_BANKS];
    end
  end

  // registered dispatch slots, strobes and pointer advance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid   <= '0;
      slotWave    <= '0;
      waveBlock   <= '0;
      waveRequeue <= '0;
      for (int r = 0; r < NUM_RES; r++) rrPtr[r] <= '0;
    end else begin
      logic [NUM_WAVES-1:0] blk;
      logic [NUM_WAVES-1:0] req;
      blk = '0;
      req = '0;
      for (int r = 0; r < NUM_RES; r++) begin
        slotValid[r] <= verdict[r].keep;
        slotWave[r*WAVE_W +: WAVE_W] <= verdict[r].keep ? candWave[r] : '0;
        if (verdict[r].keep) begin
          blk[candWave[r]] = 1'b1;
          rrPtr[r] <= (int'(candWave[r]) == NUM_WAVES-1) ? '0 : candWave[r] + 1'b1;
        end
        if (verdict[r].evict) req[candWave[r]] = 1'b1;
      end
      waveBlock   <= blk;
      waveRequeue <= req;
    end
  end
endmodule

// File: rtl/wave_issue_arb.sv
module wave_issue_arb
  import wave_issue_pkg::*;
#(
  parameter int NUM_SIMD  = 2,
  parameter int NUM_RES   = 4,
  parameter int NUM_BANKS = 4,
  parameter int SIMD_W    = 1
) (
  input  logic [NUM_RES-1:0]           candFill,
  input  logic [NUM_RES*SIMD_W-1:0]    candSimd,
  input  logic [NUM_RES*NUM_BANKS-1:0] candBanks,
  output slotVerdict_t                 verdict [NUM_RES]
);
  // second pass: memory-pipe slots in ascending order take read-port priority
  always_comb begin
    logic [NUM_RES-1:0] alive;
    alive = candFill;
    for (int j = NUM_SIMD; j < NUM_RES; j++) begin
      logic hit;
      hit = 1'b0;
      if (alive[j]) begin
        for (int i = 0; i < NUM_RES; i++) begin
          if (!hit && i != j && alive[i]
              && candSimd[i*SIMD_W +: SIMD_W] == candSimd[j*SIMD_W +: SIMD_W]
              && |(candBanks[i*NUM_BANKS +: NUM_BANKS] & candBanks[j*NUM_BANKS +: NUM_BANKS])) begin
            alive[i] = 1'b0;
            hit      = 1'b1;
          end
        end
      end
    end
    for (int r = 0; r < NUM_RES; r++) begin
      verdict[r].keep  = alive[r];
      verdict[r].evict = candFill[r] & ~alive[r];
    end
  end
endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched
  import wave_issue_pkg::*;
#(
  parameter int NUM_SIMD       = 2,
  parameter int NUM_GMEM_PIPES = 1,
  parameter int NUM_SMEM_PIPES = 1,
  parameter int NUM_WAVES      = 4,
  parameter int NUM_BANKS      = 4,
  localparam int NUM_MEM = NUM_GMEM_PIPES + NUM_SMEM_PIPES,
  localparam int NUM_RES = NUM_SIMD + NUM_MEM,
  localparam int SIMD_W  = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1,
  localparam int WAVE_W  = (NUM_WAVES > 1) ? $clog2(NUM_WAVES) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_RES*NUM_WAVES-1:0]   readyMask,
  input  logic [NUM_WAVES*SIMD_W-1:0]    waveSimd,
  input  logic [NUM_WAVES*NUM_BANKS-1:0] waveBanks,
  output logic [NUM_RES-1:0]             slotValid,
  output logic [NUM_RES*WAVE_W-1:0]      slotWave,
  output logic [NUM_WAVES-1:0]           waveBlock,
  output logic [NUM_WAVES-1:0]           waveRequeue
);
  logic [NUM_RES-1:0]           candFill;
  logic [NUM_RES*SIMD_W-1:0]    candSimd;
  logic [NUM_RES*NUM_BANKS-1:0] candBanks;
  slotVerdict_t                 verdict [NUM_RES];

  wave_issue_pick #(
    .NUM_RES(NUM_RES), .NUM_WAVES(NUM_WAVES), .NUM_BANKS(NUM_BANKS),
    .SIMD_W(SIMD_W), .WAVE_W(WAVE_W)
  ) datapath (
    .clk(clk), .rstN(rstN), .readyMask(readyMask), .waveSimd(waveSimd),
    .waveBanks(waveBanks), .verdict(verdict), .candFill(candFill),
    .candSimd(candSimd), .candBanks(candBanks), .slotValid(slotValid),
    .slotWave(slotWave), .waveBlock(waveBlock), .waveRequeue(waveRequeue)
  );

  wave_issue_arb #(
    .NUM_SIMD(NUM_SIMD), .NUM_RES(NUM_RES), .NUM_BANKS(NUM_BANKS), .SIMD_W(SIMD_W)
  ) control (
    .candFill(candFill), .candSimd(candSimd), .candBanks(candBanks), .verdict(verdict)
  );
endmodule

// File: rtl/wave_issue_sched_chk.sv
module wave_issue_sched_chk #(
  parameter int NUM_SIMD  = 2,
  parameter int NUM_RES   = 4,
  parameter int NUM_MEM   = 2,
  parameter int NUM_WAVES = 4,
  parameter int WAVE_W    = 2
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_RES*NUM_WAVES-1:0] readyMask,
  input logic [NUM_RES-1:0]           slotValid,
  input logic [NUM_RES*WAVE_W-1:0]    slotWave,
  input logic [NUM_WAVES-1:0]         waveBlock,
  input logic [NUM_WAVES-1:0]         waveRequeue
);
  logic [NUM_RES*NUM_WAVES-1:0] prevReady;
  logic                         armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevReady <= '0;
      armed     <= 1'b0;
    end else begin
      prevReady <= readyMask;
      armed     <= 1'b1;
    end
  end

  for (genvar r = 0; r < NUM_RES; r++) begin : g_slot
    a_r1_idle_slot_clear: assert property (@(posedge clk) disable iff (!rstN)
      !slotValid[r] |-> slotWave[r*WAVE_W +: WAVE_W] == '0);
    a_r1_empty_ready_no_issue: assert property (@(posedge clk) disable iff (!rstN)
      !(|readyMask[r*NUM_WAVES +: NUM_WAVES]) |=> !slotValid[r]);
    a_r2_issued_wave_was_ready: assert property (@(posedge clk) disable iff (!rstN)
      (armed && slotValid[r]) |-> prevReady[r*NUM_WAVES + int'(slotWave[r*WAVE_W +: WAVE_W])]);
  end

  a_r3_block_bound: assert property (@(posedge clk) disable iff (!rstN)
    $countones(waveBlock) <= $countones(slotValid));
  a_r6_requeue_bound: assert property (@(posedge clk) disable iff (!rstN)
    $countones(waveRequeue) <= NUM_MEM);
  a_r8_no_mem_no_evict: assert property (@(posedge clk) disable iff (!rstN)
    !(|readyMask[NUM_RES*NUM_WAVES-1 : NUM_SIMD*NUM_WAVES]) |=> waveRequeue == '0);
endmodule

bind wave_issue_sched wave_issue_sched_chk #(
  .NUM_SIMD(NUM_SIMD), .NUM_RES(NUM_RES), .NUM_MEM(NUM_MEM),
  .NUM_WAVES(NUM_WAVES), .WAVE_W(WAVE_W)
) chk (.*);

// File: tb/wave_issue_sched_test.sv
module wave_issue_sched_test;
  localparam int NS = 2, NR = 4, NW = 4, NB = 4, SW = 1, WW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NR*NW-1:0] readyMask = '0;
  logic [NW*SW-1:0] waveSimd = '0;
  logic [NW*NB-1:0] waveBanks = '0;
  logic [NR-1:0]    slotValid;
  logic [NR*WW-1:0] slotWave;
  logic [NW-1:0]    waveBlock, waveRequeue;

  int checks = 0, failures = 0;
  int mptr [NR];
  logic [NR-1:0]    eValid;
  logic [NR*WW-1:0] eWave;
  logic [NW-1:0]    eBlock, eReq;
  logic [31:0]      lfsr = 32'h1ace_b00c;

  always #5 clk = ~clk;

  wave_issue_sched uut (
    .clk(clk), .rstN(rstN), .readyMask(readyMask), .waveSimd(waveSimd),
    .waveBanks(waveBanks), .slotValid(slotValid), .slotWave(slotWave),
    .waveBlock(waveBlock), .waveRequeue(waveRequeue)
  );

  task automatic setWave(int w, int simd, logic [NB-1:0] banks);
    waveSimd[w*SW +: SW]  = SW'(simd);
    waveBanks[w*NB +: NB] = banks;
  endtask

  task automatic setReady(int r, logic [NW-1:0] m);
    readyMask[r*NW +: NW] = m;
  endtask

  // expected result from the requirements, using the bench's own pointers
  task automatic predict();
    logic [NR-1:0] fill, alive;
    int pick [NR];
    fill = '0;
    for (int r = 0; r < NR; r++) begin
      pick[r] = 0;
      for (int k = 0; k < NW; k++) begin
        int idx = (mptr[r] + k) % NW;
        if (!fill[r] && readyMask[r*NW + idx]) begin fill[r] = 1'b1; pick[r] = idx; end
      end
    end
    alive = fill;
    for (int j = NS; j < NR; j++) begin
      bit hit = 0;
      if (alive[j])
        for (int i = 0; i < NR; i++)
          if (!hit && i != j && alive[i]
              && waveSimd[pick[i]*SW +: SW] == waveSimd[pick[j]*SW +: SW]
              && (waveBanks[pick[i]*NB +: NB] & waveBanks[pick[j]*NB +: NB]) != 0) begin
            alive[i] = 1'b0; hit = 1;
          end
    end
    eValid = alive; eWave = '0; eBlock = '0; eReq = '0;
    for (int r = 0; r < NR; r++) begin
      if (alive[r]) begin
        eWave[r*WW +: WW] = WW'(pick[r]);
        eBlock[pick[r]] = 1'b1;
        mptr[r] = (pick[r] + 1) % NW;
      end else if (fill[r]) eReq[pick[r]] = 1'b1;
    end
  endtask

  task automatic step(string tag);
    predict();
    @(posedge clk); #1;
    checks++;
    if (slotValid !== eValid || slotWave !== eWave || waveBlock !== eBlock || waveRequeue !== eReq) begin
      failures++;
      $display("FAIL %s: valid=%b wave=%h block=%b requeue=%b expected valid=%b wave=%h block=%b requeue=%b",
               tag, slotValid, slotWave, waveBlock, waveRequeue, eValid, eWave, eBlock, eReq);
    end
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) mptr[r] = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (slotValid !== '0 || slotWave !== '0 || waveBlock !== '0 || waveRequeue !== '0) begin
      failures++;
      $display("FAIL R9: valid=%b block=%b requeue=%b expected all zero", slotValid, waveBlock, waveRequeue);
    end
    rstN = 1'b1;
    step("R9");
    step("R1");   // all ready masks empty

    // R5: memory pipe 2 against SIMD slot 0, same SIMD, shared bank
    setWave(0, 0, 4'b0001); setWave(1, 0, 4'b0011);
    setWave(2, 1, 4'b0100); setWave(3, 1, 4'b1000);
    setReady(0, 4'b0001); setReady(2, 4'b0010);
    step("R5");
    step("R2");   // slot 0 pointer held, same pick again

    // R4: different SIMD, then same SIMD with disjoint banks
    setWave(1, 1, 4'b0001);
    step("R4");
    setWave(1, 0, 4'b0110);
    step("R4");

    // R6: both SIMD slots conflict with memory slot 2, only slot 0 loses
    setWave(0, 0, 4'b0001); setWave(1, 0, 4'b0010); setWave(2, 0, 4'b0011);
    setReady(0, 4'b0001); setReady(1, 4'b0010); setReady(2, 4'b0100); setReady(3, 4'b0000);
    step("R6");
    step("R6");

    // R7: memory 2 evicts memory 3, which then cannot evict SIMD slot 1
    setWave(0, 1, 4'b1000); setWave(1, 0, 4'b0010);
    setWave(2, 0, 4'b0001); setWave(3, 0, 4'b0011);
    setReady(0, 4'b0001); setReady(1, 4'b0010); setReady(2, 4'b0100); setReady(3, 4'b1000);
    step("R7");

    // R8: SIMD slots clash with each other, no memory issue
    setWave(0, 0, 4'b1111); setWave(1, 0, 4'b1111);
    setReady(0, 4'b0001); setReady(1, 4'b0010); setReady(2, '0); setReady(3, '0);
    step("R8");

    // R2: round robin walk and wrap on slot 0
    setReady(1, '0); setReady(0, 4'b1111);
    for (int n = 0; n < 6; n++) step("R2");
    setReady(0, 4'b1010);
    for (int n = 0; n < 4; n++) step("R2");

    // R3: pseudo-random sweep with dense conflicts
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      readyMask = lfsr[15:0] & {lfsr[31:16] | lfsr[23:8]};
      for (int w = 0; w < NW; w++) begin
        logic [NB-1:0] b = '0;
        b[lfsr[(w*3) % 28 +: 2]] = 1'b1;
        setWave(w, int'(lfsr[w+24]), b);
      end
      step("R3");
    end

    readyMask = '0;
    rstN = 1'b0;
    @(posedge clk); #1;
    for (int r = 0; r < NR; r++) mptr[r] = 0;
    checks++;
    if (slotValid !== '0 || waveBlock !== '0 || waveRequeue !== '0) begin
      failures++;
      $display("FAIL R9: valid=%b block=%b requeue=%b expected all zero", slotValid, waveBlock, waveRequeue);
    end
    rstN = 1'b1;
    setWave(0, 0, 4'b0001); setReady(0, 4'b1111);
    step("R2");   // pointer back at zero after reset

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule